// File: doc/BRIEF.md
# Interrupt Flag and Enable Register Pair

This block holds the interrupt status of a small peripheral that sits on an 8-bit register bus. A shift unit and two timers each send one-cycle event pulses. Each pulse sets a flag bit. Software clears flags in one of two ways: it writes ones to the flag register, or it reads the data or counter register that belongs to the event. Enable bits are changed in place. Bit 7 of the written byte chooses whether the ones in bits 6:0 set enables or clear them.

The block drives one level interrupt line and returns the readback byte for its two registers. On a flag read, bit 7 shows whether any flag is set while its enable is also set. On an enable read, bit 7 always reads as one. Only the shift flag and the timer 1 flag can raise the interrupt line. The timer 2 flag is visible in the status byte but does not drive the line. The register index comes from a parameterised address slice, so 16 registers share the address space.

Top module: `evt_irq_ctl`

## Requirements
- R1: After a synchronous reset, all flags and all enables are 0, `irq_o` is low and `rd_data_o` is 0.
- R2: A pulse on `ev_shift_i` sets flag bit 2, a pulse on `ev_tmr2_i` sets flag bit 5, and a pulse on `ev_tmr1_i` sets flag bit 6. The flag is set at the next clock edge.
- R3: A write to register index 13 (the flag register) clears every flag whose bit in the written byte is 1. Bits written as 0, and bit 7, leave the flags unchanged.
- R4: A write to register index 14 (the enable register) with bit 7 = 1 sets every enable bit that is 1 in bits 6:0. The other enable bits are unchanged.
- R5: A write to index 14 with bit 7 = 0 clears every enable bit that is 1 in bits 6:0. The other enable bits are unchanged.
- R6: A read of index 13 returns the flags in bits 6:0. Bit 7 is 1 exactly when some flag and its enable are both 1, timer 2 included.
- R7: A read of index 14 returns the enables in bits 6:0, with bit 7 always 1.
- R8: `irq_o` is high exactly when (flag 2 and enable 2) or (flag 6 and enable 6) is true. Flag 5 never affects `irq_o`.
- R9: Reading index 10 clears flag 2. Reading index 4 clears flag 6. Reading index 8 clears flag 5. Reading any other index, such as 5 or 9, clears no flag.
- R10: If an event pulse and a clear of the same flag arrive in one cycle, the flag ends up set.
- R11: The register index is address bits 12:9, and the other address bits are ignored. Reads of indices other than 13 and 14 return 0.
- R12: `rd_data_o` is loaded at the clock edge that samples `rd_i` and holds its value until the next read. `irq_o` changes at the same edge as the flags and enables it depends on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 13 | Byte address; bits 12:9 select the register |
| wdata_i | input | 8 | Write data |
| ev_shift_i | input | 1 | Shift unit event pulse |
| ev_tmr1_i | input | 1 | Timer 1 event pulse |
| ev_tmr2_i | input | 1 | Timer 2 event pulse |
| rd_data_o | output | 8 | Registered readback byte |
| irq_o | output | 1 | Registered level interrupt |

## Verification
Several rules are checked at every clock edge by assertions:
- an event sets its flag, even when a clear arrives in the same cycle;
- writes clear flags and set or clear enables;
- the interrupt line matches the two lines that can raise it;
- the enable readback carries its constant bit 7.

Other behaviours can only be shown by the bench's scenarios, because they need a reference history:
- the full readback bytes;
- which reads clear which flag, and which reads leave the flags alone;
- that unused address bits have no effect;
- that the timer 2 flag is seen in the summary bit 7 but never on `irq_o`.

A model in the bench tracks these across long random mixes of accesses.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int FLG_BIT_SHIFT = 2;
  localparam int FLG_BIT_TMR2  = 5;
  localparam int FLG_BIT_TMR1  = 6;
  localparam int REG_FLAGS     = 13;
  localparam int REG_ENABLES   = 14;
  localparam int REG_SHIFT_DAT = 10;
  localparam int REG_TMR1_LO   = 4;
  localparam int REG_TMR2_LO   = 8;
endpackage

// File: rtl/evt_irq_decode.sv
module evt_irq_decode
  import evt_irq_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int IDX_LSB = 9,
  parameter int IDX_W   = 4,
  parameter int FLG_W   = 7
) (
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wr_flags_o,
  output logic              wr_enables_o,
  output logic              rd_flags_o,
  output logic              rd_enables_o,
  output logic [FLG_W-1:0]  rd_clr_o
);
  logic [IDX_W-1:0] idx;

  assign idx          = addr_i[IDX_LSB +: IDX_W];
  assign wr_flags_o   = wr_i && (idx == IDX_W'(REG_FLAGS));
  assign wr_enables_o = wr_i && (idx == IDX_W'(REG_ENABLES));
  assign rd_flags_o   = rd_i && (idx == IDX_W'(REG_FLAGS));
  assign rd_enables_o = rd_i && (idx == IDX_W'(REG_ENABLES));

  always_comb begin
    rd_clr_o = '0;
    rd_clr_o[FLG_BIT_SHIFT] = rd_i && (idx == IDX_W'(REG_SHIFT_DAT));
    rd_clr_o[FLG_BIT_TMR1]  = rd_i && (idx == IDX_W'(REG_TMR1_LO));
    rd_clr_o[FLG_BIT_TMR2]  = rd_i && (idx == IDX_W'(REG_TMR2_LO));
  end
endmodule

// File: rtl/evt_irq_flags.sv
module evt_irq_flags #(
  parameter int FLG_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [FLG_W-1:0] set_i,
  input  logic [FLG_W-1:0] clr_i,
  output logic [FLG_W-1:0] flag_q_o,
  output logic [FLG_W-1:0] flag_d_o
);
  genvar g;
  generate
    for (g = 0; g < FLG_W; g++) begin : g_bit
      assign flag_d_o[g] = set_i[g] | (flag_q_o[g] & ~clr_i[g]);
      always_ff @(posedge clk) begin
        if (rst) flag_q_o[g] <= 1'b0;
        else     flag_q_o[g] <= flag_d_o[g];
      end
    end
  endgenerate
endmodule

// File: rtl/evt_irq_enables.sv
module evt_irq_enables #(
  parameter int FLG_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic             set_mode_i,
  input  logic [FLG_W-1:0] bits_i,
  output logic [FLG_W-1:0] en_q_o,
  output logic [FLG_W-1:0] en_d_o
);
  always_comb begin
    en_d_o = en_q_o;
    if (wr_i) begin
      if (set_mode_i) en_d_o = en_q_o | bits_i;
      else            en_d_o = en_q_o & ~bits_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) en_q_o <= '0;
    else     en_q_o <= en_d_o;
  end
endmodule

// File: rtl/evt_irq_status.sv
module evt_irq_status
  import evt_irq_pkg::*;
#(
  parameter int FLG_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_i,
  input  logic             rd_flags_i,
  input  logic             rd_enables_i,
  input  logic [FLG_W-1:0] flag_q_i,
  input  logic [FLG_W-1:0] en_q_i,
  input  logic [FLG_W-1:0] flag_d_i,
  input  logic [FLG_W-1:0] en_d_i,
  output logic [FLG_W:0]   rd_data_o,
  output logic             irq_o
);
  localparam logic [FLG_W-1:0] LINE_MASK =
    (FLG_W'(1) << FLG_BIT_SHIFT) | (FLG_W'(1) << FLG_BIT_TMR1);

  logic [FLG_W:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (rd_flags_i)   rd_mux = {|(flag_q_i & en_q_i), flag_q_i};
    if (rd_enables_i) rd_mux = {1'b1, en_q_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
      irq_o     <= 1'b0;
    end else begin
      if (rd_i) rd_data_o <= rd_mux;
      irq_o <= |(flag_d_i & en_d_i & LINE_MASK);
    end
  end
endmodule

// File: rtl/evt_irq_ctl.sv
module evt_irq_ctl
  import evt_irq_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int IDX_LSB = 9,
  parameter int IDX_W   = 4,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ev_shift_i,
  input  logic              ev_tmr1_i,
  input  logic              ev_tmr2_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  localparam int FLG_W = DATA_W - 1;

  logic             wr_flags, wr_enables, rd_flags, rd_enables;
  logic [FLG_W-1:0] rd_clr, ev_set, flag_clr;
  logic [FLG_W-1:0] flag_q, flag_d, en_q, en_d;

  evt_irq_decode #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W), .FLG_W(FLG_W)) u_dec (
    .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
    .wr_flags_o(wr_flags), .wr_enables_o(wr_enables),
    .rd_flags_o(rd_flags), .rd_enables_o(rd_enables), .rd_clr_o(rd_clr)
  );

  always_comb begin
    ev_set = '0;
    ev_set[FLG_BIT_SHIFT] = ev_shift_i;
    ev_set[FLG_BIT_TMR1]  = ev_tmr1_i;
    ev_set[FLG_BIT_TMR2]  = ev_tmr2_i;
  end

  assign flag_clr = rd_clr | (wr_flags ? wdata_i[FLG_W-1:0] : '0);

  evt_irq_flags #(.FLG_W(FLG_W)) u_flg (
    .clk(clk), .rst(rst), .set_i(ev_set), .clr_i(flag_clr),
    .flag_q_o(flag_q), .flag_d_o(flag_d)
  );

  evt_irq_enables #(.FLG_W(FLG_W)) u_en (
    .clk(clk), .rst(rst), .wr_i(wr_enables), .set_mode_i(wdata_i[DATA_W-1]),
    .bits_i(wdata_i[FLG_W-1:0]), .en_q_o(en_q), .en_d_o(en_d)
  );

  evt_irq_status #(.FLG_W(FLG_W)) u_st (
    .clk(clk), .rst(rst), .rd_i(rd_i), .rd_flags_i(rd_flags), .rd_enables_i(rd_enables),
    .flag_q_i(flag_q), .en_q_i(en_q), .flag_d_i(flag_d), .en_d_i(en_d),
    .rd_data_o(rd_data_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/evt_irq_ctl_chk.sv
module evt_irq_ctl_chk #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              ev_shift_i,
  input logic              ev_tmr1_i,
  input logic [DATA_W-2:0] flag_q,
  input logic [DATA_W-2:0] en_q,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              irq_o
);
  logic [3:0] idx;
  assign idx = addr_i[12:9];

  // R2 R10
  shift_evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
    ev_shift_i |=> flag_q[2]);

  // R2 R10
  tmr1_evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
    ev_tmr1_i |=> flag_q[6]);

  // R3
  flag_w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !rd_i && idx == 4'd13 && wdata_i[6] && !ev_tmr1_i) |=> !flag_q[6]);

  // R4
  en_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && idx == 4'd14 && wdata_i[7]) |=> ((en_q & $past(wdata_i[6:0])) == $past(wdata_i[6:0])));

  // R5
  en_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && idx == 4'd14 && !wdata_i[7]) |=> ((en_q & $past(wdata_i[6:0])) == '0));

  // R7
  en_read_top_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && idx == 4'd14) |=> rd_data_o[7]);

  // R8
  irq_line_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == ((flag_q[2] && en_q[2]) || (flag_q[6] && en_q[6])));

  // R9
  shift_rd_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && idx == 4'd10 && !ev_shift_i) |=> !flag_q[2]);
endmodule

bind evt_irq_ctl evt_irq_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .ev_shift_i(ev_shift_i), .ev_tmr1_i(ev_tmr1_i), .flag_q(flag_q), .en_q(en_q),
  .rd_data_o(rd_data_o), .irq_o(irq_o)
);

// File: tb/sim_evt_irq_ctl.sv
module sim_evt_irq_ctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [12:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        ev_shift_i = 1'b0, ev_tmr1_i = 1'b0, ev_tmr2_i = 1'b0;
  logic [7:0]  rd_data_o;
  logic        irq_o;

  int n_chk = 0, n_bad = 0;
  logic [6:0] m_flg = '0, m_en = '0;
  logic [7:0] m_rd = '0;

  evt_irq_ctl u0 (.*);

  always #2 clk = ~clk;

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  function automatic logic [12:0] mk_addr(input int idx, input logic [8:0] low, input logic [2:0] hi);
    return {idx[3:0], low};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, update model, sample after edge
  task automatic cyc(input logic w, input logic r, input int idx, input logic [7:0] d,
                     input logic es, input logic e1, input logic e2, input logic [8:0] low);
    logic [6:0] clr, set;
    @(negedge clk);
    wr_i = w; rd_i = r; addr_i = {idx[3:0], low}; wdata_i = d;
    ev_shift_i = es; ev_tmr1_i = e1; ev_tmr2_i = e2;
    if (r) begin
      if (idx == 13)      m_rd = {|(m_flg & m_en), m_flg};
      else if (idx == 14) m_rd = {1'b1, m_en};
      else                m_rd = 8'h00;
    end
    clr = '0;
    if (w && idx == 13) clr = d[6:0];
    if (r && idx == 10) clr[2] = 1'b1;
    if (r && idx == 4)  clr[6] = 1'b1;
    if (r && idx == 8)  clr[5] = 1'b1;
    set = '0; set[2] = es; set[6] = e1; set[5] = e2;
    m_flg = set | (m_flg & ~clr);
    if (w && idx == 14) m_en = d[7] ? (m_en | d[6:0]) : (m_en & ~d[6:0]);
    @(posedge clk); #1;
    wr_i = 0; rd_i = 0; ev_shift_i = 0; ev_tmr1_i = 0; ev_tmr2_i = 0;
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0, 0); endtask
  function automatic logic exp_irq(); return (m_flg[2] & m_en[2]) | (m_flg[6] & m_en[6]); endfunction

  task automatic rd_check(input int idx, input string req);
    cyc(0, 1, idx, 0, 0, 0, 0, 9'h0a5);
    check(req, rd_data_o, m_rd);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    // R1 reset state
    check("R1 irq", {7'd0, irq_o}, 8'h00);
    check("R1 rd_data", rd_data_o, 8'h00);
    rd_check(13, "R1 flags");
    rd_check(14, "R1 enables");

    // R2 events set flags, R7 enable bit7
    cyc(0, 0, 0, 0, 1, 1, 1, 0);
    check("R12 irq stays low without enables", {7'd0, irq_o}, 8'h00);
    rd_check(13, "R2 flag bits 2/5/6");
    // R4 set enables: timer2 only -> no irq (R8), summary bit 1 (R6)
    cyc(1, 0, 14, 8'ha0, 0, 0, 0, 0);
    check("R8 timer2 no irq", {7'd0, irq_o}, 8'h00);
    rd_check(13, "R6 summary from timer2");
    rd_check(14, "R7 enable readback");
    cyc(1, 0, 14, 8'hc4, 0, 0, 0, 0);
    check("R8 irq rises with enable", {7'd0, irq_o}, 8'h01);
    // R5 clear enable 6 only
    cyc(1, 0, 14, 8'h40, 0, 0, 0, 0);
    check("R5 clear one enable", {7'd0, irq_o}, {7'd0, exp_irq()});
    rd_check(14, "R5 enables after clear");
    // R9 reads 5 and 9 do not clear, 10/4/8 do
    rd_check(5, "R11 other index reads 0");
    rd_check(9, "R9 no clear by index 9");
    rd_check(13, "R9 flags intact");
    rd_check(10, "R9 shift read");
    check("R9 irq drop after shift read", {7'd0, irq_o}, {7'd0, exp_irq()});
    rd_check(8, "R9 t2 read");
    rd_check(13, "R9 flags after clears");
    // R10 event vs clear same cycle
    cyc(0, 1, 4, 0, 0, 1, 0, 0);
    rd_check(13, "R10 tmr1 event beats read clear");
    cyc(1, 0, 13, 8'hff, 1, 0, 0, 0);
    rd_check(13, "R10 shift event beats write clear");
    // R3 write-one-to-clear with zeros preserved
    cyc(0, 0, 0, 0, 1, 1, 1, 0);
    cyc(1, 0, 13, 8'h84, 0, 0, 0, 0);
    rd_check(13, "R3 partial clear");
    // R11 alias: high address bits vary, low bits ignored
    cyc(1, 0, 14, 8'hff, 0, 0, 0, 9'h1ff);
    rd_check(14, "R11 low bits ignored");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int idx;
      logic w, r;
      idx = int'($urandom(0) % 16);
      if (i == 0) idx = int'($urandom(32'h5eed) % 16);
      case ($urandom % 4)
        0: idx = 13;
        1: idx = 14;
        default: ;
      endcase
      w = ($urandom % 3) == 0;
      r = !w && (($urandom % 2) == 0);
      cyc(w, r, idx, 8'($urandom), ($urandom % 5) == 0, ($urandom % 5) == 0,
          ($urandom % 5) == 0, 9'($urandom));
      check("R8 random irq", {7'd0, irq_o}, {7'd0, exp_irq()});
      if (r) check("R6 R7 R12 random readback", rd_data_o, m_rd);
    end

    // R1 reset again mid-run
    @(negedge clk); rst = 1; @(negedge clk); rst = 0; m_flg = '0; m_en = '0; m_rd = '0;
    #1;
    check("R1 re-reset irq", {7'd0, irq_o}, 8'h00);
    rd_check(14, "R1 re-reset enables");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule